// File: doc/BRIEF.md
# Next Program Counter Branch Unit

This block owns the 16-bit program counter of an 8-bit microcontroller core and works out the next fetch address once per instruction. The decoder supplies a branch class, the opcode byte and up to two operand bytes. Surrounding logic supplies a taken/not-taken condition, the value popped from the stack, and the current accumulator and data pointer. From these the block picks one of several outcomes: a sequential advance, a page-absolute target, a long absolute target, a signed relative target, an indirect accumulator-plus-pointer target, or a return address.

The counter moves only when the core pulses the instruction-complete strobe. Between strobes the combinational next-address output tracks the inputs, so the fetch logic can look ahead. For calls the block also presents the address of the following instruction, so the stack logic can push it. Condition evaluation, stack storage, fetch and arithmetic on data are handled elsewhere.

Branch class encoding on `br_class`: 0 sequential, 1 page-absolute (jump or call), 2 long jump, 3 long call, 4 two-byte relative, 5 three-byte relative, 6 indirect, 7 return.

Top module: `npc_branch_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to 0x0000 at the next rising edge, whatever the other inputs are.
- R2: `pc` loads `next_pc` on a rising edge where `step_done` is 1 and holds its value when `step_done` is 0.
- R3: Class 0 gives `next_pc = pc + seq_len`, where `seq_len` (1 to 3) is the instruction length in bytes.
- R4: Class 1 gives `next_pc = {F[15:11], opcode[7:5], opnd_a}`, where F = pc + 2. So the target stays in the 2K page of the following instruction.
- R5: Classes 2 and 3 give `next_pc = {opnd_a, opnd_b}`, with `opnd_a` as the high byte.
- R6: Class 4 gives `next_pc = pc + 2 + sext(opnd_a)` when `cond_taken` is 1, and `pc + 2` when it is 0.
- R7: Class 5 gives `next_pc = pc + 3 + sext(opnd_b)` when `cond_taken` is 1, and `pc + 3` when it is 0. `opnd_a` has no effect in this class.
- R8: Class 6 gives `next_pc = dptr + acc`, with the accumulator zero-extended.
- R9: Class 7 gives `next_pc = ret_addr`.
- R10: `call_active` is 1 for class 3, and for class 1 when `opcode[4]` is 1. In that case `call_link` is pc + 3 for class 3 and pc + 2 for class 1. `call_active` is 0 for every other class and opcode.
- R11: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_done | input | 1 | One-cycle instruction-complete strobe |
| br_class | input | 3 | Branch class of the current instruction |
| seq_len | input | 2 | Instruction length for class 0 |
| opcode | input | 8 | Opcode byte |
| opnd_a | input | 8 | First operand byte |
| opnd_b | input | 8 | Second operand byte |
| cond_taken | input | 1 | Branch condition result |
| ret_addr | input | 16 | Popped return address |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| pc | output | 16 | Current program counter |
| next_pc | output | 16 | Address the counter will load on the next strobe |
| call_active | output | 1 | Current instruction is a call |
| call_link | output | 16 | Return address to push for a call |

## Verification
The bench targets page-absolute branches placed just below a 2K boundary. A design that takes the page from the opcode address instead of the following instruction lands one page low. It drives relative offsets of -128 and +127 near 0x0000 and 0xFFFF. A wrong sign extension or a wrong base (opcode address, or the wrong operand byte for three-byte forms) shows up as an off-by-length or off-by-256 target. Indirect sums that carry past 0xFFFF, not-taken branches, and cycles without a strobe are also covered. Together these expose a missing wrap, a missing fall-through and a counter that moves on its own.

// File: rtl/npc_pkg.sv
package npc_pkg;
  parameter int unsigned PC_W   = 16;
  parameter int unsigned BYTE_W = 8;
  localparam int unsigned PAGE_LSB = 11;

  typedef enum logic [2:0] {
    BC_SEQ   = 3'd0,
    BC_PAGE  = 3'd1,
    BC_LJMP  = 3'd2,
    BC_LCALL = 3'd3,
    BC_REL2  = 3'd4,
    BC_REL3  = 3'd5,
    BC_INDIR = 3'd6,
    BC_RET   = 3'd7
  } br_class_e;

  function automatic logic [PC_W-1:0] f_advance(input logic [PC_W-1:0] base,
                                               input logic [1:0] len);
    return base + PC_W'(len);
  endfunction

  function automatic logic [PC_W-1:0] f_page_target(input logic [PC_W-1:0] fall,
                                                   input logic [BYTE_W-1:0] opc,
                                                   input logic [BYTE_W-1:0] low);
    return {fall[PC_W-1:PAGE_LSB], opc[7:5], low};
  endfunction

  function automatic logic [PC_W-1:0] f_rel_target(input logic [PC_W-1:0] fall,
                                                  input logic [BYTE_W-1:0] off);
    return fall + {{(PC_W-BYTE_W){off[BYTE_W-1]}}, off};
  endfunction

  function automatic logic [PC_W-1:0] f_indirect(input logic [BYTE_W-1:0] a,
                                                input logic [PC_W-1:0] ptr);
    return ptr + PC_W'(a);
  endfunction
endpackage

// File: rtl/npc_fallthrough.sv
module npc_fallthrough
  import npc_pkg::*;
(
  input  br_class_e       cls,
  input  logic [1:0]      seq_len,
  input  logic [PC_W-1:0] pc,
  output logic [1:0]      len,
  output logic [PC_W-1:0] fall_pc
);
  always_comb begin
    unique case (cls)
      BC_SEQ:            len = seq_len;
      BC_PAGE, BC_REL2:  len = 2'd2;
      BC_LJMP, BC_LCALL,
      BC_REL3:           len = 2'd3;
      BC_INDIR:          len = 2'd1;
      default:           len = 2'd1;
    endcase
  end

  assign fall_pc = f_advance(pc, len);
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
  import npc_pkg::*;
(
  input  br_class_e         cls,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] opnd_a,
  input  logic [BYTE_W-1:0] opnd_b,
  input  logic              cond_taken,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic [BYTE_W-1:0] acc,
  input  logic [PC_W-1:0]   dptr,
  input  logic [PC_W-1:0]   fall_pc,
  output logic [PC_W-1:0]   target,
  output logic              is_call
);
  logic [PC_W-1:0] page_tgt, long_tgt, rel2_tgt, rel3_tgt, ind_tgt;

  assign page_tgt = f_page_target(fall_pc, opcode, opnd_a);
  assign long_tgt = {opnd_a, opnd_b};
  assign rel2_tgt = f_rel_target(fall_pc, opnd_a);
  assign rel3_tgt = f_rel_target(fall_pc, opnd_b);
  assign ind_tgt  = f_indirect(acc, dptr);

  always_comb begin
    target = fall_pc;
    unique case (cls)
      BC_SEQ:            target = fall_pc;
      BC_PAGE:           target = page_tgt;
      BC_LJMP, BC_LCALL: target = long_tgt;
      BC_REL2:           target = cond_taken ? rel2_tgt : fall_pc;
      BC_REL3:           target = cond_taken ? rel3_tgt : fall_pc;
      BC_INDIR:          target = ind_tgt;
      BC_RET:            target = ret_addr;
      default:           target = fall_pc;
    endcase
  end

  assign is_call = (cls == BC_LCALL) || ((cls == BC_PAGE) && opcode[4]);
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int unsigned W        = 16,
  parameter logic [W-1:0] RESET_V = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_V;
    else if (load) q <= d;
  end
endmodule

// File: rtl/npc_branch_unit.sv
module npc_branch_unit
  import npc_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step_done,
  input  logic [2:0]  br_class,
  input  logic [1:0]  seq_len,
  input  logic [7:0]  opcode,
  input  logic [7:0]  opnd_a,
  input  logic [7:0]  opnd_b,
  input  logic        cond_taken,
  input  logic [15:0] ret_addr,
  input  logic [7:0]  acc,
  input  logic [15:0] dptr,
  output logic [15:0] pc,
  output logic [15:0] next_pc,
  output logic        call_active,
  output logic [15:0] call_link
);
  br_class_e       cls;
  logic [1:0]      len;
  logic [PC_W-1:0] fall_pc;
  logic [PC_W-1:0] target;
  logic            is_call;

  assign cls = br_class_e'(br_class);

  npc_fallthrough u_fall (
    .cls     (cls),
    .seq_len (seq_len),
    .pc      (pc),
    .len     (len),
    .fall_pc (fall_pc)
  );

  npc_target_gen u_tgt (
    .cls        (cls),
    .opcode     (opcode),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .cond_taken (cond_taken),
    .ret_addr   (ret_addr),
    .acc        (acc),
    .dptr       (dptr),
    .fall_pc    (fall_pc),
    .target     (target),
    .is_call    (is_call)
  );

  npc_pc_reg #(.W(PC_W), .RESET_V(RESET_PC)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .load (step_done),
    .d    (target),
    .q    (pc)
  );

  assign next_pc     = target;
  assign call_active = is_call;
  assign call_link   = fall_pc;
endmodule

// File: rtl/npc_branch_unit_chk.sv
module npc_branch_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        step_done,
  input logic [2:0]  br_class,
  input logic [7:0]  opcode,
  input logic        cond_taken,
  input logic [15:0] ret_addr,
  input logic [15:0] pc,
  input logic [15:0] next_pc,
  input logic        call_active,
  input logic [15:0] call_link
);
  logic [15:0] pc_p2, pc_p3;
  assign pc_p2 = pc + 16'd2;
  assign pc_p3 = pc + 16'd3;

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !step_done |=> $stable(pc));

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    step_done |=> pc == $past(next_pc));

  a_r9_return: assert property (@(posedge clk) disable iff (rst)
    (step_done && br_class == 3'd7) |=> pc == $past(ret_addr));

  a_r4_page: assert property (@(posedge clk) disable iff (rst)
    (br_class == 3'd1) |-> (next_pc[15:11] == pc_p2[15:11] && next_pc[10:8] == opcode[7:5]));

  a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
    (br_class == 3'd4 && !cond_taken) |-> next_pc == pc_p2);

  a_r7_not_taken: assert property (@(posedge clk) disable iff (rst)
    (br_class == 3'd5 && !cond_taken) |-> next_pc == pc_p3);

  a_r10_link: assert property (@(posedge clk) disable iff (rst)
    call_active |-> (call_link == pc_p2 || call_link == pc_p3));

  a_r10_no_call: assert property (@(posedge clk) disable iff (rst)
    (br_class != 3'd1 && br_class != 3'd3) |-> !call_active);
endmodule

bind npc_branch_unit npc_branch_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .step_done   (step_done),
  .br_class    (br_class),
  .opcode      (opcode),
  .cond_taken  (cond_taken),
  .ret_addr    (ret_addr),
  .pc          (pc),
  .next_pc     (next_pc),
  .call_active (call_active),
  .call_link   (call_link)
);

// File: tb/npc_branch_unit_bench.sv
module npc_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_done = 1'b0;
  logic [2:0]  br_class = 3'd0;
  logic [1:0]  seq_len = 2'd1;
  logic [7:0]  opcode = 8'h00, opnd_a = 8'h00, opnd_b = 8'h00, acc = 8'h00;
  logic        cond_taken = 1'b0;
  logic [15:0] ret_addr = 16'h0000, dptr = 16'h0000;
  logic [15:0] pc, next_pc, call_link;
  logic        call_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int model_pc = 0;

  always #2 clk = ~clk;

  npc_branch_unit u_npc_branch_unit (
    .clk(clk), .rst(rst), .step_done(step_done), .br_class(br_class),
    .seq_len(seq_len), .opcode(opcode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .cond_taken(cond_taken), .ret_addr(ret_addr), .acc(acc), .dptr(dptr),
    .pc(pc), .next_pc(next_pc), .call_active(call_active), .call_link(call_link)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ilen(input int c, input int sl);
    case (c)
      0: return sl;
      1, 4: return 2;
      2, 3, 5: return 3;
      6: return 1;
      default: return 1;
    endcase
  endfunction

  function automatic int sbyte(input int b);
    return (b >= 128) ? b - 256 : b;
  endfunction

  function automatic int expect_next(input int p, input int c, input int sl, input int opc,
                                     input int a, input int b, input int cnd,
                                     input int r, input int ac, input int dp);
    int f;
    f = (p + ilen(c, sl)) % 65536;
    case (c)
      0: return f;
      1: return (f / 2048) * 2048 + (opc / 32) * 256 + a;
      2, 3: return a * 256 + b;
      4: return cnd ? (f + sbyte(a) + 65536) % 65536 : f;
      5: return cnd ? (f + sbyte(b) + 65536) % 65536 : f;
      6: return (ac + dp) % 65536;
      default: return r;
    endcase
  endfunction

  function automatic string rtag(input int c);
    case (c)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic do_step(input int c, input int sl, input int opc, input int a,
                         input int b, input int cnd, input int r, input int ac,
                         input int dp, input bit strobe);
    int en;
    int ecall;
    @(negedge clk);
    br_class = 3'(c); seq_len = 2'(sl); opcode = 8'(opc); opnd_a = 8'(a);
    opnd_b = 8'(b); cond_taken = cnd[0]; ret_addr = 16'(r); acc = 8'(ac);
    dptr = 16'(dp); step_done = strobe;
    #1;
    en = expect_next(model_pc, c, sl, opc, a, b, cnd, r, ac, dp);
    check(rtag(c), int'(next_pc), en);
    ecall = (c == 3 || (c == 1 && (opc / 16) % 2 == 1)) ? 1 : 0;
    check("R10 call_active", int'(call_active), ecall);
    if (ecall == 1) check("R10 call_link", int'(call_link), (model_pc + ilen(c, sl)) % 65536);
    @(posedge clk);
    #1;
    if (strobe) model_pc = en;
    check(strobe ? "R2 load" : "R2 hold", int'(pc), model_pc);
    step_done = 1'b0;
  endtask

  task automatic set_pc(input int v);
    do_step(2, 1, 8'h02, v / 256, v % 256, 0, 0, 0, 0, 1'b1);
  endtask

  initial begin
    int c, sl, opc, a, b, cnd, r, ac, dp;
    bit stb;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", int'(pc), 0);
    @(negedge clk);
    rst = 1'b0;

    // R3 sequential lengths
    do_step(0, 1, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    do_step(0, 3, 0, 0, 0, 0, 0, 0, 0, 1'b1);
    // R4 page boundary: next instruction already in page 1
    set_pc(16'h07FE);
    do_step(1, 1, 8'hE1, 8'h34, 0, 0, 0, 0, 0, 1'b1);
    check("R4 page boundary", int'(pc), 16'h0F34);
    // R4/R10 page call
    set_pc(16'h3456);
    do_step(1, 1, 8'h51, 8'h9A, 0, 0, 0, 0, 0, 1'b1);
    // R7 wrap at top of space, R11
    set_pc(16'hFFFE);
    do_step(5, 1, 8'h20, 8'hAA, 8'h7F, 1, 0, 0, 0, 1'b1);
    check("R11 rel wrap", int'(pc), 16'h0080);
    // R6 backward -128 from bottom
    set_pc(16'h0000);
    do_step(4, 1, 8'h80, 8'h80, 8'h00, 1, 0, 0, 0, 1'b1);
    check("R6 back -128", int'(pc), 16'hFF82);
    // R6 not taken
    do_step(4, 1, 8'h40, 8'h10, 0, 0, 0, 0, 0, 1'b1);
    // R8 indirect carry past top
    do_step(6, 1, 8'h73, 0, 0, 0, 0, 8'hFF, 16'hFFF0, 1'b1);
    check("R8 indirect wrap", int'(pc), 16'h00EF);
    // R9 return, R2 hold
    do_step(7, 1, 8'h22, 0, 0, 0, 16'hBEEF, 0, 0, 1'b1);
    do_step(2, 1, 8'h02, 8'h12, 8'h34, 0, 0, 0, 0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      c = $urandom_range(0, 7);
      sl = $urandom_range(1, 3);
      opc = $urandom_range(0, 255);
      a = $urandom_range(0, 255);
      b = $urandom_range(0, 255);
      cnd = $urandom_range(0, 1);
      r = $urandom_range(0, 65535);
      ac = $urandom_range(0, 255);
      dp = $urandom_range(0, 65535);
      stb = ($urandom_range(0, 7) != 0);
      do_step(c, sl, opc, a, b, cnd, r, ac, dp, stb);
    end

    // R1 reset mid-run, with strobe asserted
    @(negedge clk);
    rst = 1'b1; step_done = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset mid-run", int'(pc), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule